// File: doc/BRIEF.md
# Multichannel TDM Serial Transmitter

This block is a time-division-multiplexed serial transmitter. It runs on the bit clock. A frame sync pulse starts a frame. After a programmable lead-in, the frame carries a window of channel slots, and each slot is one 16-bit word long. In a slot whose channel is enabled, the block shifts a word out MSB first with the output enable high. In a disabled slot, the output enable stays low, so the line is left undriven.

Words come from a word-wide source through a valid/ready handshake. A packing select chooses between two source layouts:
- **Sparse (non-packed):** the source holds one word for every slot of the window. The word belonging to a disabled slot is taken and thrown away.
- **Packed:** the source holds words only for the enabled slots.

The lead-in before the window has two parts. The frame delay adds that many bit clocks. The window offset adds that many whole slots.

All configuration inputs are sampled only in the cycle that carries the frame sync. They are held for the rest of the frame.

Top module: `tdm_tx`

## Requirements
- R1: An enabled slot is 16 bit clocks long. The slot's word is driven on `sdo` MSB first, one bit per clock, with `sdo_oe` high for all 16 clocks.
- R2: In a disabled slot, and whenever `sdo_oe` is low, `sdo` is 0 and `sdo_oe` is 0.
- R3: Enabled channels transmit in ascending channel order within each window. In sparse mode with channel 0 disabled and a source of words w0..w7 per 8-slot window, every window carries w1..w7 with no carry-over between windows.
- R4: In sparse mode (`pack_mode`=0), each slot takes exactly one source word at its start. A word taken for a disabled slot never reaches `sdo`.
- R5: In packed mode (`pack_mode`=1), only enabled slots take a source word, one each. Disabled slots take none.
- R6: The window begins `win_offset`×16 bit clocks after the lead-in given by R7.
- R7: With `frame_delay`=0 and `win_offset`=0, bit 15 of slot 0 appears on the clock edge that samples `fsync`. A value d delays the start by d bit clocks.
- R8: If no word is valid when an enabled slot begins, the slot sends 16 zeros with `sdo_oe` high, and `underflow` goes high. `underflow` stays high until reset.
- R9: `chan_en`, `win_size`, `win_offset`, `frame_delay` and `pack_mode` take effect only in a cycle with `fsync` high. Changes at other times have no effect on the current frame.
- R10: After reset, and after the last slot of a window until the next `fsync`, `sdo_oe` and `sdo` are 0 and no word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame sync pulse, one clock wide |
| chan_en | input | NCH | Per-channel enable mask; bit i enables slot i |
| win_size | input | CNT_W | Slots per window, 1..NCH (0 or values above NCH mean NCH) |
| win_offset | input | OFF_W | Lead-in in whole slots |
| frame_delay | input | DLY_W | Lead-in in bit clocks |
| pack_mode | input | 1 | 1 = packed source, 0 = sparse source |
| in_data | input | 16 | Source word |
| in_valid | input | 1 | Source word is valid |
| in_ready | output | 1 | A word is taken on this clock edge when `in_valid` is also high |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Serial data output enable |
| underflow | output | 1 | Sticky flag: an enabled slot found no valid word |

## Verification
The embedded assertions check these properties on every cycle:
- the disabled-output level, which holds whenever the enable is low;
- the stickiness of the underflow flag;
- the freezing of the latched configuration between syncs;
- the idle output after the window ends;
- the effect of a take: a word taken for an enabled slot raises the enable on the next edge, and a take for a disabled slot keeps it low.

Only the bench scenarios can show the rest:
- the slot ordering and the per-window alignment in the channel-0-disabled sparse case;
- the exact placement of the lead-in formed by offset and delay;
- how words are consumed in each packing mode;
- that a mid-frame change to the configuration inputs leaves the frame untouched.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
    localparam int WORD_W = 16;
    localparam int BIT_W  = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);
endpackage

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser
    import tdm_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_oe,
    input  logic [WORD_W-1:0] load_word,
    input  logic              step,
    output logic              sdo,
    output logic              sdo_oe
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic              dat;
        logic              oe;
    } ser_t;

    ser_t ser_d, ser_q;

    always_comb begin
        ser_d = ser_q;
        if (load) begin
            ser_d.dat = load_word[WORD_W-1];
            ser_d.sh  = {load_word[WORD_W-2:0], 1'b0};
            ser_d.oe  = load_oe;
        end else if (step) begin
            ser_d.dat = ser_q.sh[WORD_W-1] & ser_q.oe;
            ser_d.sh  = {ser_q.sh[WORD_W-2:0], 1'b0};
        end else begin
            ser_d.dat = 1'b0;
            ser_d.oe  = 1'b0;
            ser_d.sh  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= '0;
        else        ser_q <= ser_d;
    end

    assign sdo    = ser_q.dat;
    assign sdo_oe = ser_q.oe;

    // R2: undriven line is held low
    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
    import tdm_tx_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int OFF_W = 4,
    parameter int DLY_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fsync,
    input  logic [NCH-1:0]           chan_en,
    input  logic [$clog2(NCH+1)-1:0] win_size,
    input  logic [OFF_W-1:0]         win_offset,
    input  logic [DLY_W-1:0]         frame_delay,
    input  logic                     pack_mode,
    input  logic [15:0]              in_data,
    input  logic                     in_valid,
    output logic                     in_ready,
    output logic                     sdo,
    output logic                     sdo_oe,
    output logic                     underflow
);
    localparam int SLOT_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CNT_W  = $clog2(NCH + 1);
    localparam int PRE_W  = ((OFF_W + BIT_W) > DLY_W ? (OFF_W + BIT_W) : DLY_W) + 1;

    typedef struct packed {
        logic [NCH-1:0]   en;
        logic [CNT_W-1:0] win;
        logic             pack;
    } cfg_t;

    typedef struct packed {
        cfg_t              cfg;
        logic              active;
        logic [PRE_W-1:0]  pre;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
        logic              under;
    } st_t;

    st_t q, d, s;
    logic              load, load_oe, step;
    logic [WORD_W-1:0] load_word;
    logic [CNT_W-1:0]  win_eff;

    always_comb begin
        if (win_size == '0 || win_size > CNT_W'(NCH)) win_eff = CNT_W'(NCH);
        else                                          win_eff = win_size;
    end

    always_comb begin
        s = q;
        if (fsync) begin
            s.cfg.en   = chan_en;
            s.cfg.win  = win_eff;
            s.cfg.pack = pack_mode;
            s.active   = 1'b1;
            s.pre      = PRE_W'(frame_delay) + (PRE_W'(win_offset) << BIT_W);
            s.slot     = '0;
            s.bitn     = '0;
        end
        d         = s;
        load      = 1'b0;
        load_oe   = 1'b0;
        step      = 1'b0;
        in_ready  = 1'b0;
        load_word = '0;
        if (s.active) begin
            if (s.pre != '0) begin
                d.pre = s.pre - 1'b1;
            end else begin
                if (s.bitn == '0) begin
                    load = 1'b1;
                    if (s.cfg.en[s.slot]) begin
                        load_oe  = 1'b1;
                        in_ready = 1'b1;
                        if (in_valid) load_word = in_data;
                        else          d.under   = 1'b1;
                    end else begin
                        in_ready = !s.cfg.pack;
                    end
                end else begin
                    step = 1'b1;
                end
                d.bitn = s.bitn + 1'b1;
                if (s.bitn == BIT_LAST) begin
                    d.slot = s.slot + 1'b1;
                    if ((CNT_W'(s.slot) + CNT_W'(1)) == s.cfg.win) d.active = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    tdm_tx_ser u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_oe  (load_oe),
        .load_word(load_word),
        .step     (step),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

    assign underflow = q.under;

    // R8: flag is sticky
    a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);
    // R9: latched configuration only moves on a sync
    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fsync |=> $stable(q.cfg));
    // R10: nothing driven once the window is over
    a_r10_idle_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.active && !fsync) |=> !sdo_oe);
    // R1: a word taken for an enabled slot is driven next edge
    a_r1_take_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !fsync && q.cfg.en[q.slot]) |=> sdo_oe);
    // R4: a word taken for a disabled slot is never driven
    a_r4_discard_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !fsync && !q.cfg.en[q.slot]) |=> !sdo_oe);
endmodule

// File: tb/tdm_tx_tb.sv
module tdm_tx_tb;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic [7:0]  chan_en = '0;
    logic [3:0]  win_size = '0;
    logic [3:0]  win_offset = '0;
    logic [3:0]  frame_delay = '0;
    logic        pack_mode = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready, sdo, sdo_oe, underflow;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] src_q[$];
    logic [15:0] model_q[$];
    logic        exp_oe_q[$];
    logic        exp_d_q[$];
    string       exp_tag_q[$];
    bit          take = 1'b0;
    bit          exp_under = 1'b0;

    always #2 clk = ~clk;

    tdm_tx #(.NCH(NCH), .OFF_W(4), .DLY_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .chan_en(chan_en),
        .win_size(win_size), .win_offset(win_offset), .frame_delay(frame_delay),
        .pack_mode(pack_mode), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .sdo(sdo), .sdo_oe(sdo_oe), .underflow(underflow)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected bit per clock edge
    always @(posedge clk) begin
        #1;
        if (exp_oe_q.size() > 0) begin
            logic eo, ed;
            string tg;
            eo = exp_oe_q.pop_front();
            ed = exp_d_q.pop_front();
            tg = exp_tag_q.pop_front();
            check(tg, {14'd0, sdo_oe, sdo}, {14'd0, eo, ed});
        end
    end

    task automatic push_exp(logic oe, logic dv, string tag, int n);
        for (int i = 0; i < n; i++) begin
            exp_oe_q.push_back(oe);
            exp_d_q.push_back(dv);
            exp_tag_q.push_back(tag);
        end
    endtask

    task automatic supply(int n, logic [15:0] base);
        for (int i = 0; i < n; i++) begin
            src_q.push_back(base + 16'(i));
            model_q.push_back(base + 16'(i));
        end
    endtask

    task automatic run_frame(logic [7:0] en, int win, int off, int dly, bit pk,
                             int gap, bit scramble, string tag);
        int total;
        total = dly + off * 16 + win * 16 + gap;
        for (int i = 0; i < total; i++) begin
            @(negedge clk);
            if (take) void'(src_q.pop_front());
            in_valid = (src_q.size() > 0);
            in_data  = in_valid ? src_q[0] : 16'h0;
            fsync    = (i == 0);
            if (i == 0) begin
                chan_en = en; win_size = 4'(win); win_offset = 4'(off);
                frame_delay = 4'(dly); pack_mode = pk;
                push_exp(1'b0, 1'b0, {tag, " R6 R7 lead-in"}, dly + off * 16);
                for (int sl = 0; sl < win; sl++) begin
                    if (en[sl]) begin
                        logic [15:0] w;
                        if (model_q.size() > 0) w = model_q.pop_front();
                        else begin w = 16'h0; exp_under = 1'b1; end
                        for (int b = 15; b >= 0; b--)
                            push_exp(1'b1, w[b], {tag, " R1 R3 enabled slot"}, 1);
                    end else begin
                        if (!pk && model_q.size() > 0) void'(model_q.pop_front());
                        push_exp(1'b0, 1'b0, {tag, " R2 disabled slot"}, 16);
                    end
                end
                push_exp(1'b0, 1'b0, {tag, " R10 after window"}, gap);
            end
            if (scramble && i == 3) begin
                chan_en = ~en; win_size = 4'd1; pack_mode = ~pk;
                frame_delay = 4'd7; win_offset = 4'd3;
            end
            #1 take = in_valid && in_ready;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset oe", {15'd0, sdo_oe}, 16'd0);
        check("R10 reset sdo", {15'd0, sdo}, 16'd0);
        check("R10 reset ready", {15'd0, in_ready}, 16'd0);
        check("R8 reset underflow", {15'd0, underflow}, 16'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 idle ready", {15'd0, in_ready}, 16'd0);

        // R3 R4: channel 0 disabled, sparse, no offset, no delay
        for (int f = 0; f < 3; f++) begin
            supply(8, 16'hC3A0);
            run_frame(8'hFE, 8, 0, 0, 1'b0, 2, 1'b0, "ch0-off sparse");
        end
        // R5: packed, sparse mask
        supply(4, 16'h9100);
        run_frame(8'hA5, 8, 0, 0, 1'b1, 3, 1'b0, "packed");
        // R4: sparse mask, non-packed
        supply(8, 16'h7700);
        run_frame(8'h5A, 8, 0, 0, 1'b0, 1, 1'b0, "sparse mask");
        // R6 R7: offset and delay
        supply(4, 16'h4440);
        run_frame(8'h0F, 4, 2, 3, 1'b0, 2, 1'b0, "offset+delay");
        supply(3, 16'hB0B0);
        run_frame(8'h07, 3, 0, 1, 1'b1, 2, 1'b0, "delay1");
        // R9: config changes mid-frame ignored
        supply(6, 16'h2460);
        run_frame(8'h3F, 6, 1, 2, 1'b1, 2, 1'b1, "R9 mid-frame change");
        @(negedge clk);
        check("R8 no underflow yet", {15'd0, underflow}, 16'd0);
        // R8: underflow
        supply(2, 16'hE100);
        run_frame(8'h0F, 4, 0, 0, 1'b1, 2, 1'b0, "R8 underflow");
        @(negedge clk);
        check("R8 underflow set", {15'd0, underflow}, {15'd0, exp_under});
        supply(2, 16'h1357);
        run_frame(8'h03, 2, 0, 0, 1'b1, 2, 1'b0, "after underflow");
        @(negedge clk);
        check("R8 underflow sticky", {15'd0, underflow}, 16'd1);
        check("R4 R5 source drained", 16'(src_q.size()), 16'd0);
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule